// File: doc/BRIEF.md
# Multi-Slot Packet Buffer Controller

This block owns eight packet slots, each a bank of 512 lines of 32 bits. Any slot can be connected to one of four streaming ports. The slot then either drains a stored packet out to the port or fills itself from the port. A processor starts, ends and recycles transfers by writing a single packed command word. It watches progress through a status word that carries four flag groups per slot, and through a per-slot record of the most recent line that was moved.

Every slot runs its own small state machine and has its own address generator and RAM bank, so transfers on different ports proceed at the same time. A transfer begins at its first line. The address moves forward by the programmed step on each accepted line. A drain stops once the line equal to the last line has been taken. A fill stops at the end-of-packet beat, or raises a fault if it reaches the last line without one or if the port flags an error. Any finished or faulted slot drives the interrupt line.

The port codes are 0 for the serial link, 1 for the DSP pipeline, 2 for the Ethernet path and 3 for the RAM path. A port serves at most one draining slot and one filling slot at a time. When more than one slot claims a port, the lowest-numbered slot wins.

Top module: `pktpool_ctrl`

## Requirements
- R1: A command is taken when `cmd_valid` is high. Field positions in `cmd_word` are: slot [31:28] (0..7 valid, anything else does nothing), port [27:25] (0..3 valid), clear [24], drain [23], fill [22], step [21:18], last line [17:9], first line [8:0]. A word with zero or more than one of bits 24..22 set is ignored.
- R2: A drain command to an idle slot raises `rd_valid` of the named port one cycle later, carrying the line at the first address with `rd_sop` set. Each beat taken with `rd_ready` advances the address by the step. `rd_eop` marks the beat whose address equals the last line. Once that beat is taken, the slot's done flag is set on the next cycle.
- R3: A fill command to an idle slot raises `wr_ready` of the named port one cycle later. Each beat taken with `wr_valid` is stored at the current address, which then advances by the step. A beat with `wr_eop` set finishes the slot as done.
- R4: A drain or fill command clears the slot's idle flag in the next cycle. Such a command is ignored when the slot is not idle or when the port field is 4 or more.
- R5: A clear command returns the named slot to idle in the next cycle. It drops the slot's done, error and slow-path flags and abandons any transfer in progress. The port field is not used.
- R6: A done or error flag stays set until a clear names that slot.
- R7: A fill that stores a beat at the last line without `wr_eop`, or that takes a beat with `wr_err` high, sets the error flag instead of done.
- R8: The slow-path flag of a slot takes the value of `wr_slow` on the end-of-packet beat that finishes a fill. A new command to the slot and a clear both reset it.
- R9: `lastline_out` shows the address of the last beat moved by the slot selected by `lastline_sel`. It is 0 after reset and does not change until that slot moves a beat.
- R10: `irq` is high exactly when any done or error flag is set.
- R11: In `status_word`, bit n is done, bit 8+n is error, bit 16+n is idle and bit 24+n is slow-path for slot n. After reset the word is 0x00FF0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command word strobe |
| cmd_word | input | 32 | Packed command word |
| status_word | output | 32 | Per-slot done, error, idle and slow-path flags |
| irq | output | 1 | Any slot done or in error |
| lastline_sel | input | 3 | Slot whose last-line record is shown |
| lastline_out | output | 9 | Last line moved by the selected slot |
| rd_valid | output | 4 | Per port: drain beat available |
| rd_data | output | 4x32 | Per port: drain beat data |
| rd_sop | output | 4 | Per port: beat is at the first line |
| rd_eop | output | 4 | Per port: beat is at the last line |
| rd_ready | input | 4 | Per port: sink takes the beat |
| wr_valid | input | 4 | Per port: fill beat offered |
| wr_data | input | 4x32 | Per port: fill beat data |
| wr_eop | input | 4 | Per port: fill beat ends the packet |
| wr_err | input | 4 | Per port: fill beat is in error |
| wr_slow | input | 4 | Per port: packet needs firmware attention |
| wr_ready | output | 4 | Per port: a filling slot is connected |

## Verification
A command changes slot state at the clock edge that samples it, so flags, `wr_ready` and `rd_valid` reflect it one cycle after the strobe. A beat taken at an edge moves the address, and with it `rd_data`, `rd_sop`, `rd_eop` and the last-line record, on that same edge. A finishing beat makes done or error visible one cycle later, and `irq` follows with no further delay. The reference model in the bench advances its state at each rising edge from the inputs the design saw there. It compares every output a fixed offset after the falling edge, once all of these registered results have settled. Stimulus changes only on falling edges, so each comparison falls exactly in the cycle where the result is due.

// File: rtl/pktpool_pkg.sv
package pktpool_pkg;

    // command word field positions (consumed by firmware, so fixed)
    localparam int CW_SLOT_HI  = 31;
    localparam int CW_SLOT_LO  = 28;
    localparam int CW_PORT_HI  = 27;
    localparam int CW_PORT_LO  = 25;
    localparam int CW_CLEAR    = 24;
    localparam int CW_DRAIN    = 23;
    localparam int CW_FILL     = 22;
    localparam int CW_STEP_HI  = 21;
    localparam int CW_STEP_LO  = 18;
    localparam int CW_LAST_HI  = 17;
    localparam int CW_LAST_LO  = 9;
    localparam int CW_FIRST_HI = 8;
    localparam int CW_FIRST_LO = 0;

    localparam int SLOT_FW = CW_SLOT_HI - CW_SLOT_LO + 1;
    localparam int PORT_FW = CW_PORT_HI - CW_PORT_LO + 1;
    localparam int STEP_W  = CW_STEP_HI - CW_STEP_LO + 1;
    localparam int LINE_W  = CW_FIRST_HI - CW_FIRST_LO + 1;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_CLEAR,
        OP_DRAIN,
        OP_FILL
    } pool_op_e;

    typedef enum logic [2:0] {
        SL_IDLE,
        SL_DRAIN,
        SL_FILL,
        SL_DONE,
        SL_FAULT
    } slot_st_e;

    typedef struct packed {
        pool_op_e              op;
        logic [SLOT_FW-1:0]    slot;
        logic [PORT_FW-1:0]    port;
        logic [STEP_W-1:0]     step;
        logic [LINE_W-1:0]     last;
        logic [LINE_W-1:0]     first;
    } pool_cmd_t;

endpackage

// File: rtl/pktpool_decode.sv
module pktpool_decode
    import pktpool_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int NPORT = 4
) (
    input  logic        cmd_valid,
    input  logic [31:0] cmd_word,
    output pool_cmd_t   cmd
);

    logic [1:0] n_ops;

    always_comb begin
        cmd.slot  = cmd_word[CW_SLOT_HI:CW_SLOT_LO];
        cmd.port  = cmd_word[CW_PORT_HI:CW_PORT_LO];
        cmd.step  = cmd_word[CW_STEP_HI:CW_STEP_LO];
        cmd.last  = cmd_word[CW_LAST_HI:CW_LAST_LO];
        cmd.first = cmd_word[CW_FIRST_HI:CW_FIRST_LO];
        n_ops     = 2'(cmd_word[CW_CLEAR]) + 2'(cmd_word[CW_DRAIN]) + 2'(cmd_word[CW_FILL]);
        cmd.op    = OP_NONE;
        if (cmd_valid && n_ops == 2'd1 && int'(cmd.slot) < NSLOT) begin
            if (cmd_word[CW_CLEAR]) begin
                cmd.op = OP_CLEAR;
            end else if (int'(cmd.port) < NPORT) begin
                cmd.op = cmd_word[CW_DRAIN] ? OP_DRAIN : OP_FILL;
            end
        end
    end

endmodule

// File: rtl/pktpool_ram.sv
module pktpool_ram #(
    parameter int AW = 9,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
    end

    assign rdata = mem[addr];

endmodule

// File: rtl/pktpool_slot.sv
module pktpool_slot
    import pktpool_pkg::*;
#(
    parameter int SLOT_ID = 0,
    parameter int AW      = 9,
    parameter int PSW     = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  pool_cmd_t      cmd,
    input  logic           rd_grant,
    input  logic           rd_ready,
    input  logic           wr_grant,
    input  logic           wr_valid,
    input  logic           wr_eop,
    input  logic           wr_err,
    input  logic           wr_slow,
    output slot_st_e       st,
    output logic [PSW-1:0] port,
    output logic [AW-1:0]  addr,
    output logic [AW-1:0]  first,
    output logic [AW-1:0]  last,
    output logic [AW-1:0]  lastl,
    output logic           slow,
    output logic           ram_we
);

    typedef struct packed {
        slot_st_e          st;
        logic [PSW-1:0]    port;
        logic [STEP_W-1:0] step;
        logic [AW-1:0]     first;
        logic [AW-1:0]     last;
        logic [AW-1:0]     addr;
        logic [AW-1:0]     lastl;
        logic              slow;
    } slot_reg_t;

    slot_reg_t s_d, s_q;
    logic      hit;
    logic      at_end;

    always_comb begin
        s_d    = s_q;
        ram_we = 1'b0;
        hit    = (cmd.op != OP_NONE) && (int'(cmd.slot) == SLOT_ID);
        at_end = (s_q.addr == s_q.last);
        if (hit && cmd.op == OP_CLEAR) begin
            s_d.st   = SL_IDLE;
            s_d.slow = 1'b0;
        end else if (hit && s_q.st == SL_IDLE) begin
            s_d.st    = (cmd.op == OP_DRAIN) ? SL_DRAIN : SL_FILL;
            s_d.port  = PSW'(cmd.port);
            s_d.step  = cmd.step;
            s_d.first = AW'(cmd.first);
            s_d.last  = AW'(cmd.last);
            s_d.addr  = AW'(cmd.first);
            s_d.slow  = 1'b0;
        end else begin
            case (s_q.st)
                SL_DRAIN: begin
                    if (rd_grant && rd_ready) begin
                        s_d.lastl = s_q.addr;
                        if (at_end) begin
                            s_d.st = SL_DONE;
                        end else begin
                            s_d.addr = s_q.addr + AW'(s_q.step);
                        end
                    end
                end
                SL_FILL: begin
                    if (wr_grant && wr_valid) begin
                        ram_we    = 1'b1;
                        s_d.lastl = s_q.addr;
                        if (wr_err) begin
                            s_d.st = SL_FAULT;
                        end else if (wr_eop) begin
                            s_d.st   = SL_DONE;
                            s_d.slow = wr_slow;
                        end else if (at_end) begin
                            s_d.st = SL_FAULT;
                        end else begin
                            s_d.addr = s_q.addr + AW'(s_q.step);
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign st    = s_q.st;
    assign port  = s_q.port;
    assign addr  = s_q.addr;
    assign first = s_q.first;
    assign last  = s_q.last;
    assign lastl = s_q.lastl;
    assign slow  = s_q.slow;

endmodule

// File: rtl/pktpool_ctrl.sv
module pktpool_ctrl
    import pktpool_pkg::*;
#(
    parameter int NSLOT = 8,
    parameter int NLINE = 512,
    parameter int DW    = 32,
    parameter int NPORT = 4,
    localparam int AW   = $clog2(NLINE),
    localparam int SELW = $clog2(NSLOT),
    localparam int PSW  = $clog2(NPORT),
    localparam int STW  = 4 * NSLOT
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      cmd_valid,
    input  logic [31:0]               cmd_word,
    output logic [STW-1:0]            status_word,
    output logic                      irq,
    input  logic [SELW-1:0]           lastline_sel,
    output logic [AW-1:0]             lastline_out,
    output logic [NPORT-1:0]          rd_valid,
    output logic [NPORT-1:0][DW-1:0]  rd_data,
    output logic [NPORT-1:0]          rd_sop,
    output logic [NPORT-1:0]          rd_eop,
    input  logic [NPORT-1:0]          rd_ready,
    input  logic [NPORT-1:0]          wr_valid,
    input  logic [NPORT-1:0][DW-1:0]  wr_data,
    input  logic [NPORT-1:0]          wr_eop,
    input  logic [NPORT-1:0]          wr_err,
    input  logic [NPORT-1:0]          wr_slow,
    output logic [NPORT-1:0]          wr_ready
);

    pool_cmd_t cmd;

    slot_st_e          slot_st    [NSLOT];
    logic [PSW-1:0]    slot_port  [NSLOT];
    logic [AW-1:0]     slot_addr  [NSLOT];
    logic [AW-1:0]     slot_first [NSLOT];
    logic [AW-1:0]     slot_last  [NSLOT];
    logic [AW-1:0]     slot_lastl [NSLOT];
    logic [DW-1:0]     ram_q      [NSLOT];
    logic [DW-1:0]     sl_wdata   [NSLOT];
    logic [NSLOT-1:0]  slot_slow;
    logic [NSLOT-1:0]  slot_we;
    logic [NSLOT-1:0]  rd_grant;
    logic [NSLOT-1:0]  wr_grant;
    logic [NSLOT-1:0]  sl_rd_ready;
    logic [NSLOT-1:0]  sl_wr_valid;
    logic [NSLOT-1:0]  sl_wr_eop;
    logic [NSLOT-1:0]  sl_wr_err;
    logic [NSLOT-1:0]  sl_wr_slow;
    logic [NPORT-1:0]  rd_taken;
    logic [NPORT-1:0]  wr_taken;
    logic [NSLOT-1:0]  f_done;
    logic [NSLOT-1:0]  f_err;
    logic [NSLOT-1:0]  f_idle;

    pktpool_decode #(
        .NSLOT (NSLOT),
        .NPORT (NPORT)
    ) u_decode (
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .cmd       (cmd)
    );

    for (genvar g = 0; g < NSLOT; g++) begin : g_slot
        pktpool_slot #(
            .SLOT_ID (g),
            .AW      (AW),
            .PSW     (PSW)
        ) u_slot (
            .clk      (clk),
            .rst_n    (rst_n),
            .cmd      (cmd),
            .rd_grant (rd_grant[g]),
            .rd_ready (sl_rd_ready[g]),
            .wr_grant (wr_grant[g]),
            .wr_valid (sl_wr_valid[g]),
            .wr_eop   (sl_wr_eop[g]),
            .wr_err   (sl_wr_err[g]),
            .wr_slow  (sl_wr_slow[g]),
            .st       (slot_st[g]),
            .port     (slot_port[g]),
            .addr     (slot_addr[g]),
            .first    (slot_first[g]),
            .last     (slot_last[g]),
            .lastl    (slot_lastl[g]),
            .slow     (slot_slow[g]),
            .ram_we   (slot_we[g])
        );

        pktpool_ram #(
            .AW (AW),
            .DW (DW)
        ) u_ram (
            .clk   (clk),
            .we    (slot_we[g]),
            .addr  (slot_addr[g]),
            .wdata (sl_wdata[g]),
            .rdata (ram_q[g])
        );

        assign f_done[g] = (slot_st[g] == SL_DONE);
        assign f_err[g]  = (slot_st[g] == SL_FAULT);
        assign f_idle[g] = (slot_st[g] == SL_IDLE);
    end

    // port arbitration: lowest slot index claims a port per direction
    always_comb begin
        rd_taken = '0;
        wr_taken = '0;
        rd_valid = '0;
        rd_data  = '0;
        rd_sop   = '0;
        rd_eop   = '0;
        wr_ready = '0;
        rd_grant = '0;
        wr_grant = '0;
        for (int s = 0; s < NSLOT; s++) begin
            sl_rd_ready[s] = rd_ready[slot_port[s]];
            sl_wr_valid[s] = wr_valid[slot_port[s]];
            sl_wr_eop[s]   = wr_eop[slot_port[s]];
            sl_wr_err[s]   = wr_err[slot_port[s]];
            sl_wr_slow[s]  = wr_slow[slot_port[s]];
            sl_wdata[s]    = wr_data[slot_port[s]];
            if (slot_st[s] == SL_DRAIN && !rd_taken[slot_port[s]]) begin
                rd_taken[slot_port[s]] = 1'b1;
                rd_grant[s]            = 1'b1;
                rd_valid[slot_port[s]] = 1'b1;
                rd_data[slot_port[s]]  = ram_q[s];
                rd_sop[slot_port[s]]   = (slot_addr[s] == slot_first[s]);
                rd_eop[slot_port[s]]   = (slot_addr[s] == slot_last[s]);
            end
            if (slot_st[s] == SL_FILL && !wr_taken[slot_port[s]]) begin
                wr_taken[slot_port[s]] = 1'b1;
                wr_grant[s]            = 1'b1;
                wr_ready[slot_port[s]] = 1'b1;
            end
        end
    end

    assign status_word  = {slot_slow, f_idle, f_err, f_done};
    assign irq          = |{f_err, f_done};
    assign lastline_out = slot_lastl[lastline_sel];

endmodule

// File: rtl/pktpool_ctrl_chk.sv
module pktpool_ctrl_chk #(
    parameter int NSLOT = 8,
    parameter int NPORT = 4
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cmd_valid,
    input logic [31:0]          cmd_word,
    input logic [4*NSLOT-1:0]   status_word,
    input logic                 irq
);

    logic       one_op;
    logic [3:0] c_slot;
    logic [2:0] c_port;

    assign one_op = ($countones(cmd_word[24:22]) == 1);
    assign c_slot = cmd_word[31:28];
    assign c_port = cmd_word[27:25];

    for (genvar n = 0; n < NSLOT; n++) begin : g_chk
        logic clr_n;
        logic start_n;
        assign clr_n   = cmd_valid && one_op && cmd_word[24] && (c_slot == 4'(n));
        assign start_n = cmd_valid && one_op && !cmd_word[24] && (c_slot == 4'(n))
                         && (int'(c_port) < NPORT);

        // R6: done holds until a clear names the slot
        a_r6_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (status_word[n] && !clr_n) |=> status_word[n]);

        // R6: error holds until a clear names the slot
        a_r6_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
            (status_word[NSLOT+n] && !clr_n) |=> status_word[NSLOT+n]);

        // R4: a start on an idle slot leaves idle
        a_r4_start_leaves_idle: assert property (@(posedge clk) disable iff (!rst_n)
            (start_n && status_word[2*NSLOT+n]) |=> !status_word[2*NSLOT+n]);

        // R5: clear returns the slot to a clean idle
        a_r5_clear_to_idle: assert property (@(posedge clk) disable iff (!rst_n)
            clr_n |=> (status_word[2*NSLOT+n] && !status_word[n]
                       && !status_word[NSLOT+n] && !status_word[3*NSLOT+n]));

        // R10: any finished or faulted slot raises the interrupt
        a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
            (status_word[n] || status_word[NSLOT+n]) |-> irq);
    end

endmodule

bind pktpool_ctrl pktpool_ctrl_chk #(
    .NSLOT (NSLOT),
    .NPORT (NPORT)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_word    (cmd_word),
    .status_word (status_word),
    .irq         (irq)
);

// File: tb/pktpool_ctrl_bench.sv
module pktpool_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NSLOT = 8;
    localparam int NLINE = 512;
    localparam int NPORT = 4;
    localparam int WDOG  = 20000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic [31:0] cmd_word = '0;
    logic [31:0] status_word;
    logic irq;
    logic [2:0] lastline_sel = '0;
    logic [8:0] lastline_out;
    logic [NPORT-1:0] rd_valid, rd_sop, rd_eop;
    logic [NPORT-1:0][31:0] rd_data;
    logic [NPORT-1:0] rd_ready = '0;
    logic [NPORT-1:0] wr_valid = '0, wr_eop = '0, wr_err = '0, wr_slow = '0;
    logic [NPORT-1:0][31:0] wr_data = '0;
    logic [NPORT-1:0] wr_ready;

    int n_chk = 0;
    int n_fail = 0;
    bit sel_auto = 1'b1;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pktpool_ctrl u_pktpool_ctrl (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .status_word(status_word), .irq(irq), .lastline_sel(lastline_sel),
        .lastline_out(lastline_out), .rd_valid(rd_valid), .rd_data(rd_data),
        .rd_sop(rd_sop), .rd_eop(rd_eop), .rd_ready(rd_ready), .wr_valid(wr_valid),
        .wr_data(wr_data), .wr_eop(wr_eop), .wr_err(wr_err), .wr_slow(wr_slow),
        .wr_ready(wr_ready)
    );

    // ---------------- reference model (0 idle,1 drain,2 fill,3 done,4 error)
    int m_st[NSLOT], m_port[NSLOT], m_step[NSLOT], m_first[NSLOT];
    int m_last[NSLOT], m_addr[NSLOT], m_lastl[NSLOT];
    bit m_slow[NSLOT];
    logic [31:0] m_mem [NSLOT][NLINE];

    function automatic int owner(int p, int kind);
        for (int s = 0; s < NSLOT; s++)
            if (m_st[s] == kind && m_port[s] == p) return s;
        return -1;
    endfunction

    task automatic model_step();
        int ro[NPORT];
        int wo[NPORT];
        int b, p, nops, op;
        for (int q = 0; q < NPORT; q++) begin
            ro[q] = owner(q, 1);
            wo[q] = owner(q, 2);
        end
        b = int'(cmd_word[31:28]);
        p = int'(cmd_word[27:25]);
        nops = int'(cmd_word[24]) + int'(cmd_word[23]) + int'(cmd_word[22]);
        op = 0;
        if (cmd_valid && nops == 1 && b < NSLOT) begin
            if (cmd_word[24]) op = 1;
            else if (p < NPORT) op = cmd_word[23] ? 2 : 3;
        end
        for (int s = 0; s < NSLOT; s++) begin
            if (op == 1 && b == s) begin
                m_st[s] = 0; m_slow[s] = 0;
            end else if (op >= 2 && b == s && m_st[s] == 0) begin
                m_st[s] = (op == 2) ? 1 : 2;
                m_port[s] = p;
                m_step[s] = int'(cmd_word[21:18]);
                m_last[s] = int'(cmd_word[17:9]);
                m_first[s] = int'(cmd_word[8:0]);
                m_addr[s] = m_first[s];
                m_slow[s] = 0;
            end else if (m_st[s] == 1 && ro[m_port[s]] == s && rd_ready[m_port[s]]) begin
                m_lastl[s] = m_addr[s];
                if (m_addr[s] == m_last[s]) m_st[s] = 3;
                else m_addr[s] = (m_addr[s] + m_step[s]) % NLINE;
            end else if (m_st[s] == 2 && wo[m_port[s]] == s && wr_valid[m_port[s]]) begin
                m_mem[s][m_addr[s]] = wr_data[m_port[s]];
                m_lastl[s] = m_addr[s];
                if (wr_err[m_port[s]]) m_st[s] = 4;
                else if (wr_eop[m_port[s]]) begin
                    m_st[s] = 3; m_slow[s] = wr_slow[m_port[s]];
                end else if (m_addr[s] == m_last[s]) m_st[s] = 4;
                else m_addr[s] = (m_addr[s] + m_step[s]) % NLINE;
            end
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < NSLOT; s++) begin
                m_st[s] = 0; m_lastl[s] = 0; m_slow[s] = 0; m_addr[s] = 0;
                m_port[s] = 0; m_first[s] = 0; m_last[s] = 0; m_step[s] = 0;
            end
        end else begin
            model_step();
        end
    end

    task automatic chk(string req, string what, logic [63:0] act, logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_status();
        logic [31:0] es = '0;
        for (int s = 0; s < NSLOT; s++) begin
            if (m_st[s] == 0) es[16+s] = 1'b1;
            if (m_st[s] == 3) es[s] = 1'b1;
            if (m_st[s] == 4) es[8+s] = 1'b1;
            es[24+s] = m_slow[s];
        end
        return es;
    endfunction

    // per-cycle comparison, away from the active edge
    initial begin
        @(posedge clk);
        forever begin
            @(negedge clk);
            #1;
            chk("R11", "status_word", 64'(status_word), 64'(exp_status()));
            chk("R10", "irq", 64'(irq), 64'(|exp_status()[15:0]));
            chk("R9", "lastline_out", 64'(lastline_out), 64'(m_lastl[lastline_sel]));
            for (int p = 0; p < NPORT; p++) begin
                int ro;
                ro = owner(p, 1);
                chk("R2", "rd_valid", 64'(rd_valid[p]), 64'(ro >= 0));
                if (ro >= 0) begin
                    chk("R2", "rd_data", 64'(rd_data[p]), 64'(m_mem[ro][m_addr[ro]]));
                    chk("R2", "rd_sop", 64'(rd_sop[p]), 64'(m_addr[ro] == m_first[ro]));
                    chk("R2", "rd_eop", 64'(rd_eop[p]), 64'(m_addr[ro] == m_last[ro]));
                end
                chk("R3", "wr_ready", 64'(wr_ready[p]), 64'(owner(p, 2) >= 0));
            end
        end
    end

    always @(negedge clk) if (sel_auto) lastline_sel <= lastline_sel + 3'd1;

    // ---------------- stimulus helpers
    function automatic logic [31:0] mk(int b, int p, int op, int step, int last, int first);
        logic [31:0] w = '0;
        w[31:28] = 4'(b);
        w[27:25] = 3'(p);
        if (op == 1) w[24] = 1'b1;
        if (op == 2) w[23] = 1'b1;
        if (op == 3) w[22] = 1'b1;
        w[21:18] = 4'(step);
        w[17:9]  = 9'(last);
        w[8:0]   = 9'(first);
        return w;
    endfunction

    task automatic send_cmd(logic [31:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_word  = '0;
    endtask

    task automatic write_pkt(int p, int n, int eop_at, int err_at, bit slow);
        for (int i = 0; i < n; i++) begin
            bit acc = 1'b0;
            if (i == 1) begin
                @(negedge clk);
                wr_valid[p] = 1'b0;
            end
            while (!acc) begin
                @(negedge clk);
                wr_valid[p] = 1'b1;
                wr_data[p]  = 32'hC0DE_0000 + 32'(p << 12) + 32'(i * 17);
                wr_eop[p]   = (i == eop_at);
                wr_err[p]   = (i == err_at);
                wr_slow[p]  = slow;
                #2;
                acc = wr_ready[p];
            end
        end
        @(negedge clk);
        wr_valid[p] = 1'b0;
        wr_eop[p] = 1'b0;
        wr_err[p] = 1'b0;
        wr_slow[p] = 1'b0;
    endtask

    task automatic drain_run(int p, int cycles);
        for (int c = 0; c < cycles; c++) begin
            @(negedge clk);
            rd_ready[p] = (c % 3 != 1);
        end
        @(negedge clk);
        rd_ready[p] = 1'b0;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    // ---------------- scenarios
    initial begin
        logic [31:0] snap;
        repeat (3) @(negedge clk);
        #1;
        chk("R11", "reset status", 64'(status_word), 64'h00FF_0000);
        chk("R10", "reset irq", 64'(irq), 64'h0);
        rst_n = 1'b1;

        // R3 / R8: fill slot 2 from the DSP port, step 2, end-of-packet on beat 3
        send_cmd(mk(2, 1, 3, 2, 20, 4));
        #1;
        chk("R4", "idle cleared on start", 64'(status_word[18]), 64'h0);
        write_pkt(1, 3, 2, -1, 1'b1);
        #1;
        chk("R3", "fill done", 64'(status_word[2]), 64'h1);
        chk("R8", "slow-path set", 64'(status_word[26]), 64'h1);

        // R4: drain to a done slot is ignored
        snap = status_word;
        send_cmd(mk(2, 3, 2, 2, 8, 4));
        #1;
        chk("R4", "busy slot ignores start", 64'(status_word), 64'(snap));
        chk("R4", "no drain on busy slot", 64'(rd_valid[3]), 64'h0);

        // R5: clear
        send_cmd(mk(2, 0, 1, 0, 0, 0));
        #1;
        chk("R5", "clear idles slot", 64'(status_word[18]), 64'h1);
        chk("R5", "clear drops slow", 64'(status_word[26]), 64'h0);
        chk("R5", "clear drops done", 64'(status_word[2]), 64'h0);

        // R2: drain lines 4,6,8 to the RAM port with a stalling sink
        send_cmd(mk(2, 3, 2, 2, 8, 4));
        drain_run(3, 10);
        #1;
        chk("R2", "drain done", 64'(status_word[2]), 64'h1);

        // R1: malformed and nil commands
        snap = status_word;
        send_cmd(mk(0, 0, 2, 1, 5, 0) | 32'h0040_0000);
        #1;
        chk("R1", "two command bits ignored", 64'(status_word), 64'(snap));
        send_cmd(mk(8, 0, 3, 1, 5, 0));
        #1;
        chk("R1", "nil slot ignored", 64'(status_word), 64'(snap));
        send_cmd(mk(0, 4, 3, 1, 5, 0));
        #1;
        chk("R4", "nil port ignored", 64'(status_word), 64'(snap));
        send_cmd(32'h0);
        #1;
        chk("R1", "no command bits ignored", 64'(status_word), 64'(snap));

        // R7: fill reaching last line without end-of-packet
        send_cmd(mk(5, 0, 3, 1, 12, 10));
        write_pkt(0, 3, -1, -1, 1'b0);
        #1;
        chk("R7", "overrun faults", 64'(status_word[13]), 64'h1);
        chk("R7", "overrun not done", 64'(status_word[5]), 64'h0);
        // R7: port error on second beat
        send_cmd(mk(6, 2, 3, 3, 100, 0));
        write_pkt(2, 2, -1, 1, 1'b0);
        #1;
        chk("R7", "port error faults", 64'(status_word[14]), 64'h1);

        // R9: last-line record of slot 5
        sel_auto = 1'b0;
        @(negedge clk);
        lastline_sel = 3'd5;
        #1;
        chk("R9", "slot 5 last line", 64'(lastline_out), 64'd12);
        sel_auto = 1'b1;

        // R6: flags persist
        wait_cyc(5);
        chk("R6", "error sticky", 64'(status_word[14:13]), 64'h3);
        chk("R6", "done sticky", 64'(status_word[2]), 64'h1);

        // concurrent drain and fill on different ports
        send_cmd(mk(2, 0, 1, 0, 0, 0));
        send_cmd(mk(2, 3, 2, 2, 8, 4));
        send_cmd(mk(3, 1, 3, 1, 3, 0));
        fork
            drain_run(3, 10);
            write_pkt(1, 4, 3, -1, 1'b0);
        join
        #1;
        chk("R2", "concurrent drain done", 64'(status_word[2]), 64'h1);
        chk("R3", "concurrent fill done", 64'(status_word[3]), 64'h1);
        chk("R8", "slow clear when port not slow", 64'(status_word[27]), 64'h0);

        // R5: clear aborts a stalled drain
        send_cmd(mk(2, 0, 1, 0, 0, 0));
        send_cmd(mk(2, 0, 2, 1, 9, 4));
        wait_cyc(3);
        chk("R2", "stalled drain presents", 64'(rd_valid[0]), 64'h1);
        send_cmd(mk(2, 0, 1, 0, 0, 0));
        #1;
        chk("R5", "abort idles", 64'(status_word[18]), 64'h1);
        chk("R5", "abort drops stream", 64'(rd_valid[0]), 64'h0);

        // R10: irq falls when every flag is cleared
        send_cmd(mk(3, 0, 1, 0, 0, 0));
        send_cmd(mk(5, 0, 1, 0, 0, 0));
        chk("R10", "irq held by slot 6", 64'(irq), 64'h1);
        send_cmd(mk(6, 0, 1, 0, 0, 0));
        #1;
        chk("R10", "irq low", 64'(irq), 64'h0);
        chk("R11", "all idle", 64'(status_word), 64'h00FF_0000);

        wait_cyc(2);
        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (WDOG) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule